// File: doc/BRIEF.md
# Timestamped Event Recorder

The recorder watches a small set of external event pins, up to three. Each pin has its own enable and its own choice of edge direction. The pins are sampled on a slow tick. That tick comes from a 32768 Hz reference enable, divided by a ratio that a mode field selects. When a channel sees a qualifying edge, it does four things:

- increments a saturating 3-bit count;
- captures the packed calendar time if this is the channel's first event since it was last cleared;
- always refreshes its most-recent-event timestamp;
- raises a per-channel flag.

Any flagged channel that has its interrupt enable set drives a combined wakeup request. A channel can also be set to pulse a clear request to external backup storage when it records an event. That pulse also latches a sticky status bit.

Software reaches control, status, counts and stamps through a word-addressed register port. Reads are combinational. Writes take effect at the clock edge. Writing ones to the status register clears individual flags.

Top module: `event_stamp_recorder`

## Requirements
- R1: The control register holds, for channel c, interrupt enable at bit 10c, auto-clear at bit 10c+1, polarity at bit 10c+2 and input enable at bit 10c+3, with the mode in bits 31:30. It reads back the written value with all other bits zero; for three channels a write of all ones reads back 0xC0F03C0F.
- R2: Mode 0 stops sampling. Modes 1, 2 and 3 produce one sample tick every DIV_SLOW, DIV_MID and DIV_FAST reference enables. The divider restarts from zero whenever a control write changes the mode.
- R3: Each pin passes a two-flop synchronizer. An event is detected at a tick when the channel is enabled, the previous tick's sample was at the inactive level and the current sample is at the active level. Polarity 1 selects a rising edge and polarity 0 a falling edge. A disabled channel never records.
- R4: Each channel counts events in a 3-bit counter that stops at 7. The counter appears in the counts register (address 2) at bits 8c+2:8c.
- R5: When an event arrives on a channel whose count is 0, the calendar input is stored as that channel's first stamp. Every event stores the calendar input as the last stamp. Stamps are 26 bits: seconds 5:0, minutes 11:6, hours 16:12, day of year 25:17.
- R6: An event sets status bit c. Writing 1 to status bit c clears that flag, the count and both stamps of channel c. If an event arrives in the same cycle as the clear, the channel records it as a fresh first event.
- R7: Status bit 31 and the wake_req output are high exactly while some channel has both its flag and its interrupt enable set.
- R8: An event on a channel with auto-clear set drives gp_clear high for exactly the next cycle and sets status bit 3. Writing 1 to status bit 3 clears it, unless a new auto-clear event arrives in the same cycle.
- R9: After reset, control, status, counts and all stamps read zero, and wake_req and gp_clear are low.
- R10: The register addresses are: status at 0, control at 1, counts at 2, first stamps at 4+c, last stamps at 8+c. Every other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| ev_pin | input | NCH | Asynchronous event inputs |
| cal_stamp | input | STAMP_W | Packed calendar time |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wake_req | output | 1 | Combined interrupt/wakeup request |
| gp_clear | output | 1 | One-cycle clear pulse to backup storage |

## Verification
The assertions assume that every divider ratio is at least 2, so two sample ticks are never adjacent and a gp_clear pulse cannot be followed directly by another. They also assume that a channel's count changes only through an event or a status-write clear, never through a control write.

The stimulus holds each pin level for more than two tick periods, so every intended edge is seen once. It changes the mode only through full control writes. It drives all inputs at the falling clock edge, so the synchronizer always sees stable levels.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int REG_W      = 32;
   localparam int CH_STRIDE  = 10;
   localparam int CNT_STRIDE = 8;
   localparam int GPF_BIT    = 3;
   localparam int WAKE_BIT   = 31;
   localparam logic [3:0] A_STATUS = 4'd0;
   localparam logic [3:0] A_CTRL   = 4'd1;
   localparam logic [3:0] A_COUNTS = 4'd2;
   localparam logic [3:0] A_FIRST0 = 4'd4;
   localparam logic [3:0] A_LAST0  = 4'd8;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_SLOW = 2'd1,
      MODE_MID  = 2'd2,
      MODE_FAST = 2'd3
   } mode_e;

   // packed MSB first: en(3) pol(2) autoclr(1) inten(0)
   typedef struct packed {
      logic en;
      logic pol;
      logic autoclr;
      logic inten;
   } chan_ctl_t;

   function automatic logic [REG_W-1:0] ctl_mask(input int nch);
      logic [REG_W-1:0] m;
      m = '0;
      for (int c = 0; c < nch; c++) m[CH_STRIDE*c +: 4] = 4'hF;
      m[31:30] = 2'b11;
      return m;
   endfunction
endpackage

// File: rtl/esr_tick_gen.sv
module esr_tick_gen
   import esr_pkg::*;
#(
   parameter int DIV_SLOW = 2048,
   parameter int DIV_MID  = 512,
   parameter int DIV_FAST = 33
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ref_en,
   input  mode_e mode,
   input  logic  restart,
   output logic  tick
);
   localparam int MAXD = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                              : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
   localparam int CW = $clog2(MAXD + 1);

   if (DIV_SLOW < 2 || DIV_MID < 2 || DIV_FAST < 2) begin : g_bad_div
      $error("esr_tick_gen: every divider ratio must be at least 2");
   end

   logic [CW-1:0] cnt, lim;

   always_comb begin
      case (mode)
         MODE_SLOW: lim = CW'(DIV_SLOW - 1);
         MODE_MID:  lim = CW'(DIV_MID - 1);
         MODE_FAST: lim = CW'(DIV_FAST - 1);
         default:   lim = '0;
      endcase
   end

   assign tick = ref_en && (mode != MODE_OFF) && (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt <= '0;
      else if (restart || mode == MODE_OFF) cnt <= '0;
      else if (ref_en)                     cnt <= tick ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/esr_channel.sv
module esr_channel
   import esr_pkg::*;
#(
   parameter int STAMP_W     = 26,
   parameter int CNT_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_pin,
   input  logic               tick,
   input  chan_ctl_t          ctl,
   input  logic               clear,
   input  logic [STAMP_W-1:0] stamp_in,
   output logic               evt,
   output logic               flag,
   output logic [CNT_W-1:0]   cnt,
   output logic [STAMP_W-1:0] first,
   output logic [STAMP_W-1:0] last
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [SYNC_STAGES-1:0] sr;
   logic lvl, prev;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("esr_channel: at least two synchronizer stages are required");
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[SYNC_STAGES-2:0], ev_pin};
      end
   end
   assign lvl = sr[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n)    prev <= 1'b0;
      else if (tick) prev <= lvl;
   end

   assign evt = tick && ctl.en && (prev != ctl.pol) && (lvl == ctl.pol);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0; first <= '0; last <= '0; flag <= 1'b0;
      end else if (evt) begin
         flag <= 1'b1;
         last <= stamp_in;
         if (clear || cnt == '0) begin
            cnt   <= CNT_W'(1);
            first <= stamp_in;
         end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end else if (clear) begin
         cnt <= '0; first <= '0; last <= '0; flag <= 1'b0;
      end
   end
endmodule

// File: rtl/event_stamp_recorder.sv
module event_stamp_recorder
   import esr_pkg::*;
#(
   parameter int NCH         = 3,
   parameter int STAMP_W     = 26,
   parameter int CNT_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_SLOW    = 2048,
   parameter int DIV_MID     = 512,
   parameter int DIV_FAST    = 33
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_en,
   input  logic [NCH-1:0]     ev_pin,
   input  logic [STAMP_W-1:0] cal_stamp,
   input  logic               reg_we,
   input  logic [3:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               wake_req,
   output logic               gp_clear
);
   localparam logic [REG_W-1:0] CTL_MASK = ctl_mask(NCH);

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("event_stamp_recorder: NCH must be 1 to 3");
   end
   if (STAMP_W > REG_W || CNT_W > CNT_STRIDE) begin : g_bad_w
      $error("event_stamp_recorder: field widths exceed register layout");
   end

   logic [REG_W-1:0]              ctl_q;
   mode_e                         mode;
   logic                          restart, tick, gpf_q;
   logic [NCH-1:0]                evt, flag, clr, ac_hit;
   chan_ctl_t                     cctl [NCH];
   logic [NCH-1:0][CNT_W-1:0]     cnt_s;
   logic [NCH-1:0][STAMP_W-1:0]   first_s, last_s;

   wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
   wire wr_stat = reg_we && (reg_addr == A_STATUS);

   assign mode    = mode_e'(ctl_q[31:30]);
   assign restart = wr_ctrl && (reg_wdata[31:30] != ctl_q[31:30]);

   always_ff @(posedge clk) begin
      if (!rst_n)       ctl_q <= '0;
      else if (wr_ctrl) ctl_q <= reg_wdata & CTL_MASK;
   end

   esr_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .mode(mode), .restart(restart), .tick(tick)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign cctl[c]   = chan_ctl_t'(ctl_q[CH_STRIDE*c +: 4]);
      assign clr[c]    = wr_stat && reg_wdata[c];
      assign ac_hit[c] = evt[c] && cctl[c].autoclr;
      esr_channel #(.STAMP_W(STAMP_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk(clk), .rst_n(rst_n), .ev_pin(ev_pin[c]), .tick(tick), .ctl(cctl[c]),
         .clear(clr[c]), .stamp_in(cal_stamp), .evt(evt[c]), .flag(flag[c]),
         .cnt(cnt_s[c]), .first(first_s[c]), .last(last_s[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpf_q    <= 1'b0;
         gp_clear <= 1'b0;
      end else begin
         gp_clear <= |ac_hit;
         if (|ac_hit)                         gpf_q <= 1'b1;
         else if (wr_stat && reg_wdata[GPF_BIT]) gpf_q <= 1'b0;
      end
   end

   always_comb begin
      wake_req = 1'b0;
      for (int c = 0; c < NCH; c++) wake_req |= flag[c] & cctl[c].inten;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STATUS) begin
         reg_rdata[NCH-1:0] = flag;
         reg_rdata[GPF_BIT] = gpf_q;
         reg_rdata[WAKE_BIT] = wake_req;
      end else if (reg_addr == A_CTRL) begin
         reg_rdata = ctl_q;
      end else if (reg_addr == A_COUNTS) begin
         for (int c = 0; c < NCH; c++) reg_rdata[CNT_STRIDE*c +: CNT_W] = cnt_s[c];
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (reg_addr == 4'(A_FIRST0 + c)) reg_rdata[STAMP_W-1:0] = first_s[c];
            if (reg_addr == 4'(A_LAST0 + c))  reg_rdata[STAMP_W-1:0] = last_s[c];
         end
      end
   end
endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
   parameter int NCH     = 3,
   parameter int STAMP_W = 26,
   parameter int CNT_W   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      tick,
   input logic [1:0]                mode_bits,
   input logic [NCH-1:0]            evt,
   input logic [NCH-1:0]            flag,
   input logic [NCH-1:0]            clr,
   input logic [NCH-1:0][CNT_W-1:0] cnt_s,
   input logic [NCH-1:0][STAMP_W-1:0] first_s,
   input logic                      wake_req,
   input logic                      gp_clear
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assert_off_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bits == 2'd0) |-> !tick);

   assert_gp_after_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gp_clear |-> $past(|evt));

   assert_gp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gp_clear |=> !gp_clear);

   assert_wake_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (|flag));

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_s[c] == CNT_MAX && !clr[c]) |=> (cnt_s[c] == CNT_MAX));

      assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !clr[c] |=> (cnt_s[c] == $past(cnt_s[c]) || cnt_s[c] == $past(cnt_s[c]) + 1'b1));

      assert_first_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_s[c] != '0 && !clr[c]) |=> $stable(first_s[c]));

      assert_evt_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         evt[c] |=> flag[c]);
   end
endmodule

bind event_stamp_recorder esr_checker #(.NCH(NCH), .STAMP_W(STAMP_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .mode_bits(ctl_q[31:30]), .evt(evt), .flag(flag),
   .clr(clr), .cnt_s(cnt_s), .first_s(first_s), .wake_req(wake_req), .gp_clear(gp_clear)
);

// File: tb/event_stamp_recorder_test.sv
module event_stamp_recorder_test;
   logic clk = 0, rst_n = 0, ref_en = 1, reg_we = 0;
   logic [2:0] ev_pin = '0;
   logic [25:0] cal_stamp = '0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic wake_req, gp_clear;
   int total = 0, bad = 0, gp_seen = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   event_stamp_recorder uut (.clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ev_pin(ev_pin),
      .cal_stamp(cal_stamp), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .wake_req(wake_req), .gp_clear(gp_clear));

   localparam logic [31:0] MASK = 32'hC0F03C0F;
   logic [31:0] m_ctl;
   logic [2:0] s1, s2, pv, fl;
   int dcnt, cn[3];
   logic [25:0] fs[3], ls[3];
   logic gpf, gpp;

   function automatic int lim(input logic [1:0] md);
      return md == 2'd1 ? 2047 : md == 2'd2 ? 511 : 32;
   endfunction

   // behavioural reference, updated at every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 0; s1 = 0; s2 = 0; pv = 0; fl = 0; dcnt = 0; gpf = 0; gpp = 0;
         for (int c = 0; c < 3; c++) begin cn[c] = 0; fs[c] = 0; ls[c] = 0; end
      end else begin
         logic [1:0] md; bit tk; bit [2:0] ev, cl;
         md = m_ctl[31:30];
         tk = ref_en && md != 0 && dcnt == lim(md);
         for (int c = 0; c < 3; c++) begin
            ev[c] = tk && m_ctl[10*c+3] && (pv[c] != m_ctl[10*c+2]) && (s2[c] == m_ctl[10*c+2]);
            cl[c] = reg_we && reg_addr == 0 && reg_wdata[c];
         end
         if (reg_we && reg_addr == 1 && reg_wdata[31:30] != md) dcnt = 0;
         else if (md == 0) dcnt = 0;
         else if (ref_en) dcnt = tk ? 0 : dcnt + 1;
         if (tk) pv = s2;
         s2 = s1; s1 = ev_pin;
         gpp = 0;
         for (int c = 0; c < 3; c++) begin
            if (ev[c]) begin
               if (cl[c] || cn[c] == 0) begin cn[c] = 1; fs[c] = cal_stamp; end
               else if (cn[c] < 7) cn[c]++;
               ls[c] = cal_stamp; fl[c] = 1;
               if (m_ctl[10*c+1]) gpp = 1;
            end else if (cl[c]) begin
               cn[c] = 0; fs[c] = 0; ls[c] = 0; fl[c] = 0;
            end
         end
         if (gpp) gpf = 1;
         else if (reg_we && reg_addr == 0 && reg_wdata[3]) gpf = 0;
         if (reg_we && reg_addr == 1) m_ctl = reg_wdata & MASK;
      end
   end

   function automatic logic m_wake();
      return (fl[0] & m_ctl[0]) | (fl[1] & m_ctl[10]) | (fl[2] & m_ctl[20]);
   endfunction

   function automatic logic [31:0] m_read(input logic [3:0] a);
      logic [31:0] r = 0;
      case (a)
         4'd0: begin r[2:0] = fl; r[3] = gpf; r[31] = m_wake(); end
         4'd1: r = m_ctl;
         4'd2: begin r[2:0] = 3'(cn[0]); r[10:8] = 3'(cn[1]); r[18:16] = 3'(cn[2]); end
         4'd4, 4'd5, 4'd6: r[25:0] = fs[a-4];
         4'd8, 4'd9, 4'd10: r[25:0] = ls[a-8];
         default: r = 0;
      endcase
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         chk(reg_rdata === m_read(reg_addr), "R10 model readback", reg_rdata, m_read(reg_addr));
         chk(wake_req === m_wake(), "R7 model wake", 32'(wake_req), 32'(m_wake()));
         chk(gp_clear === gpp, "R8 model pulse", 32'(gp_clear), 32'(gpp));
         if (gp_clear) gp_seen++;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0; reg_wdata = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a;
      @(posedge clk); #2; d = reg_rdata;
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rise(input int c, input int n);
      @(negedge clk); ev_pin[c] = 0; hold(n);
      ev_pin[c] = 1; hold(n);
   endtask

   task automatic fall(input int c, input int n);
      @(negedge clk); ev_pin[c] = 1; hold(n);
      ev_pin[c] = 0; hold(n);
   endtask

   localparam logic [25:0] STA = {9'd200, 5'd13, 6'd45, 6'd30};
   localparam logic [25:0] STB = {9'd366, 5'd23, 6'd59, 6'd59};

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(0, "watchdog expired", 0, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      hold(4); rst_n = 1;
      // R9 reset state
      rd(0, rv); chk(rv == 0, "R9 status after reset", rv, 0);
      rd(2, rv); chk(rv == 0, "R9 counts after reset", rv, 0);
      chk(!wake_req && !gp_clear, "R9 outputs after reset", {wake_req, gp_clear}, 0);
      // R1 control layout
      wr(1, 32'hFFFF_FFFF);
      rd(1, rv); chk(rv == 32'hC0F03C0F, "R1 control mask", rv, 32'hC0F03C0F);
      wr(1, 0);
      // R2 mode 0: no sampling
      wr(1, 32'h0000_000C);
      fall(0, 80); fall(0, 80);
      rd(2, rv); chk(rv == 0, "R2 mode off records nothing", rv, 0);
      // mode 3: ch0 rising, ch1 disabled, ch2 falling
      wr(1, 32'hC000_000C | (32'h1 << 23));
      cal_stamp = STA;
      fork rise(0, 80); rise(1, 80); join
      cal_stamp = STB;
      fork rise(0, 80); fall(1, 80); fall(2, 80); join
      rd(2, rv); chk(rv == 32'h0001_0002, "R3 R4 counts: rising, disabled, falling", rv, 32'h0001_0002);
      rd(4, rv); chk(rv == 32'(STA), "R5 first stamp", rv, 32'(STA));
      rd(8, rv); chk(rv == 32'(STB), "R5 last stamp", rv, 32'(STB));
      rd(6, rv); chk(rv == 32'(STB), "R5 first stamp ch2", rv, 32'(STB));
      rd(0, rv); chk(rv == 32'h5, "R6 flags", rv, 32'h5);
      wr(1, 32'hC000_000D | (32'h1 << 23));
      rd(0, rv); chk(wake_req && rv[31], "R7 wake with enable", {wake_req, rv[31]}, 2'b11);
      // R4 saturation
      for (int i = 0; i < 9; i++) rise(0, 80);
      rd(2, rv); chk(rv[2:0] == 3'd7, "R4 saturates at 7", rv[2:0], 7);
      // R6 clear
      wr(0, 32'h1);
      rd(2, rv); chk(rv == 32'h0001_0000, "R6 clear count", rv, 32'h0001_0000);
      rd(4, rv); chk(rv == 0, "R6 clear first stamp", rv, 0);
      rd(0, rv); chk(rv == 32'h4 && !wake_req, "R6 R7 status after clear", rv, 32'h4);
      // R8 auto-clear on ch1
      wr(1, 32'hC000_000D | (32'h1 << 23) | (32'h7 << 11));
      gp_seen = 0;
      rise(1, 80);
      chk(gp_seen == 1, "R8 one clear pulse", gp_seen, 1);
      rd(0, rv); chk(rv == 32'hE, "R8 status bit3 set", rv, 32'hE);
      wr(0, 32'h8);
      rd(0, rv); chk(rv == 32'h6, "R8 status bit3 cleared", rv, 32'h6);
      // R10 unused addresses
      rd(3, rv); chk(rv == 0, "R10 address 3 reads zero", rv, 0);
      rd(15, rv); chk(rv == 0, "R10 address 15 reads zero", rv, 0);
      // R2 slow mode
      wr(1, 32'h4000_000C);
      rise(0, 4200);
      rd(2, rv); chk(rv[2:0] == 3'd1, "R2 slow mode records", rv[2:0], 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule